// File: doc/BRIEF.md
# Chained Descriptor DMA Sequencer

This block is a bus-master DMA sequencer for an add-in card. Host software writes the addresses of descriptor chains into a task queue. The engine pops one chain head and reads that descriptor from host memory through a request/grant master port. The slave on that port may refuse any access with a retry. The engine then moves the buffer the descriptor names, either from host memory into local card memory or from local memory out to the host. When the move is over, it writes a completion word back into the descriptor and follows the embedded link to the next descriptor. The next head is popped only once the whole chain has been walked.

The host can track progress in two ways. It can wait for the level interrupt, which rises once per chain. It can also poll the completed-descriptor counter and the busy flag. A queue-full flag and a sticky overflow bit report pushes that could not be stored. Two write-one-to-clear bits clear the interrupt and the overflow bit.

Top module: `dma_chain_engine`

## Requirements
- R1: A push that arrives while `q_full` is low is stored, and heads are served in push order. `q_full` is high exactly when QUEUE_DEPTH heads are waiting. `busy` stays low after reset until the first push.
- R2: A push made while `q_full` is high is dropped and sets `q_overflow`. The bit stays set until a clear write with `clr_mask` bit 1 set.
- R3: For each descriptor at byte address D, the engine reads four 32-bit words in the order D+0, D+4, D+8, D+12. These hold the buffer address, the byte length, the control word and the next-descriptor address. Control bit 0 means a chain link is present. Control bit 1 gives the direction.
- R4: With direction 0, host words B+4k are read for k = 0 to len/4-1. Each word is written to local word address ((B>>2)+k) modulo 2^LOCAL_AW.
- R5: With direction 1, local words at the same addresses are read and written to host address B+4k.
- R6: After a descriptor's data moves, the engine writes its status to host address D+16. The value is 1 on success. It is 3 when the length is zero or not a multiple of 4; such a descriptor moves no data and ends its chain.
- R7: When control bit 0 is set on a good descriptor, the descriptor at the next address is processed next. Every descriptor of a chain gets its status written before any access is made for the next queued head.
- R8: `irq` rises on the clock edge that completes the status write of a chain's last descriptor, and on no other status write. It then holds as a level until a clear write with `clr_mask` bit 0 set.
- R9: `done_count` goes up by one on the clock edge that completes each status write, whether the status is success or error. It does not change at any other time.
- R10: `m_req` holds with unchanged address, direction and write data until grant or retry. After a retry it is low for exactly one cycle. The same access is then reissued, and nothing is lost.
- R11: `busy` is high from the pop of a head until its chain's last status write completes. It is low when the queue is empty and no chain is in progress.
- R12: Lengths of 4 KB and above are handled: one 4096-byte descriptor moves all 1024 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Host write pushing one chain head |
| push_addr | input | WORD_W | Byte address of the pushed chain head |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_mask | input | 2 | Bit 0 clears irq, bit 1 clears q_overflow |
| q_full | output | 1 | Task queue full |
| q_overflow | output | 1 | Sticky: a push was dropped |
| irq | output | 1 | Chain-complete interrupt, level |
| busy | output | 1 | A chain is being processed |
| done_count | output | COUNT_W | Completed descriptors, wraps |
| m_req | output | 1 | Host master access request |
| m_we | output | 1 | Access is a write |
| m_addr | output | WORD_W | Host byte address |
| m_wdata | output | WORD_W | Host write data |
| m_gnt | input | 1 | Access accepted; read data valid this cycle |
| m_retry | input | 1 | Access refused; must be reissued |
| m_rdata | input | WORD_W | Host read data |
| l_we | output | 1 | Local memory write strobe |
| l_addr | output | LOCAL_AW | Local word address |
| l_wdata | output | WORD_W | Local write data |
| l_rdata | input | WORD_W | Local read data, one cycle after l_addr |

## Verification
Every completion result is due one cycle after its grant edge. The bench samples `done_count` and `irq` on the falling edge that follows the status-write grant. At that point the counter must have advanced and the interrupt must match whether the descriptor ends its chain. The backoff is checked at the falling edge after the retry edge, where `m_req` must already be low. Data, status words, the order of status writes and the queue flags are compared once `busy` has fallen with the counter at its target. Overflow is checked one cycle after the push that hits a full queue.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POP,
    ST_FETCH,
    ST_HRD,
    ST_LADDR,
    ST_LWAIT,
    ST_LCAP,
    ST_HWR,
    ST_STAT
  } seq_state_t;

  // descriptor word indices, fetch order
  localparam logic [1:0] IDX_BUF  = 2'd0;
  localparam logic [1:0] IDX_LEN  = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [1:0] IDX_NEXT = 2'd3;

  localparam int STAT_OFFSET    = 16;
  localparam int CTRL_CHAIN_BIT = 0;
  localparam int CTRL_DIR_BIT   = 1;

  localparam logic [1:0] STAT_OK  = 2'b01;
  localparam logic [1:0] STAT_ERR = 2'b11;

endpackage

// File: rtl/dma_task_fifo.sv
module dma_task_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage kept free of reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r1_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !rd_en |=> full && $stable(wptr));

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int LOCAL_AW = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_empty,
  output logic                q_pop,
  input  logic [WORD_W-1:0]   q_head,
  output logic                m_req,
  output logic                m_we,
  output logic [WORD_W-1:0]   m_addr,
  output logic [WORD_W-1:0]   m_wdata,
  input  logic                m_gnt,
  input  logic                m_retry,
  input  logic [WORD_W-1:0]   m_rdata,
  output logic                l_we,
  output logic [LOCAL_AW-1:0] l_addr,
  output logic [WORD_W-1:0]   l_wdata,
  input  logic [WORD_W-1:0]   l_rdata,
  output logic                desc_done,
  output logic                chain_end,
  output logic                busy
);
  localparam int LA_LO = 2;
  localparam int LA_HI = LOCAL_AW + 1;

  seq_state_t        state;
  logic              hold;
  logic [1:0]        idx;
  logic [WORD_W-1:0] desc_a, buf_a, len_b, next_a, off_b, xbuf;
  logic              ctrl_chain, ctrl_dir, err;
  logic              bus_phase, acc_ok, acc_retry, last_word, len_bad;
  logic [WORD_W-1:0] data_a;

  assign data_a    = buf_a + off_b;
  assign bus_phase = state inside {ST_FETCH, ST_HRD, ST_HWR, ST_STAT};
  assign m_req     = bus_phase && !hold;
  assign m_we      = state inside {ST_HWR, ST_STAT};
  assign m_wdata   = (state == ST_STAT) ?
                     {{(WORD_W-2){1'b0}}, (err ? STAT_ERR : STAT_OK)} : xbuf;
  assign acc_ok    = m_req && m_gnt;
  assign acc_retry = m_req && m_retry && !m_gnt;
  assign last_word = ((off_b + WORD_W'(4)) == len_b);
  assign len_bad   = (len_b == '0) || (len_b[1:0] != 2'b00);
  assign q_pop     = (state == ST_IDLE) && !q_empty;
  assign busy      = (state != ST_IDLE);
  assign desc_done = (state == ST_STAT) && acc_ok;
  assign chain_end = desc_done && !(ctrl_chain && !err);

  always_comb begin
    case (state)
      ST_FETCH: m_addr = desc_a + WORD_W'({idx, 2'b00});
      ST_STAT:  m_addr = desc_a + WORD_W'(STAT_OFFSET);
      default:  m_addr = data_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hold       <= 1'b0;
      idx        <= '0;
      desc_a     <= '0;
      buf_a      <= '0;
      len_b      <= '0;
      next_a     <= '0;
      off_b      <= '0;
      xbuf       <= '0;
      ctrl_chain <= 1'b0;
      ctrl_dir   <= 1'b0;
      err        <= 1'b0;
      l_we       <= 1'b0;
      l_addr     <= '0;
      l_wdata    <= '0;
    end else begin
      l_we <= 1'b0;
      hold <= acc_retry;
      case (state)
        ST_IDLE: if (!q_empty) state <= ST_POP;
        ST_POP: begin
          desc_a <= q_head;
          idx    <= IDX_BUF;
          state  <= ST_FETCH;
        end
        ST_FETCH: if (acc_ok) begin
          case (idx)
            IDX_BUF:  buf_a <= m_rdata;
            IDX_LEN:  len_b <= m_rdata;
            IDX_CTRL: begin
              ctrl_chain <= m_rdata[CTRL_CHAIN_BIT];
              ctrl_dir   <= m_rdata[CTRL_DIR_BIT];
            end
            default:  next_a <= m_rdata;
          endcase
          idx <= idx + 1'b1;
          if (idx == IDX_NEXT) begin
            off_b <= '0;
            err   <= len_bad;
            if (len_bad)       state <= ST_STAT;
            else if (ctrl_dir) state <= ST_LADDR;
            else               state <= ST_HRD;
          end
        end
        ST_HRD: if (acc_ok) begin
          l_we    <= 1'b1;
          l_addr  <= data_a[LA_HI:LA_LO];
          l_wdata <= m_rdata;
          off_b   <= off_b + WORD_W'(4);
          if (last_word) state <= ST_STAT;
        end
        ST_LADDR: begin
          l_addr <= data_a[LA_HI:LA_LO];
          state  <= ST_LWAIT;
        end
        ST_LWAIT: state <= ST_LCAP;
        ST_LCAP: begin
          xbuf  <= l_rdata;
          state <= ST_HWR;
        end
        ST_HWR: if (acc_ok) begin
          off_b <= off_b + WORD_W'(4);
          state <= last_word ? ST_STAT : ST_LADDR;
        end
        ST_STAT: if (acc_ok) begin
          if (ctrl_chain && !err) begin
            desc_a <= next_a;
            idx    <= IDX_BUF;
            state  <= ST_FETCH;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an outstanding request is held unchanged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_gnt && !m_retry |=> m_req && $stable(m_addr) && $stable(m_we)
                                    && $stable(m_wdata));

  a_r10_backoff: assert property (@(posedge clk) disable iff (rst)
    acc_retry |=> !m_req);

  a_r10_reissue: assert property (@(posedge clk) disable iff (rst)
    acc_retry |=> ##1 (m_req && m_addr == $past(m_addr, 2) && m_we == $past(m_we, 2)));

  // R7: a head is never popped while a chain is in flight
  a_r7_pop_idle_only: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> !$past(bus_phase) || $past(chain_end));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int WORD_W      = 32,
  parameter int QUEUE_DEPTH = 128,
  parameter int LOCAL_AW    = 14,
  parameter int COUNT_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_valid,
  input  logic [WORD_W-1:0]   push_addr,
  input  logic                clr_wr,
  input  logic [1:0]          clr_mask,
  output logic                q_full,
  output logic                q_overflow,
  output logic                irq,
  output logic                busy,
  output logic [COUNT_W-1:0]  done_count,
  output logic                m_req,
  output logic                m_we,
  output logic [WORD_W-1:0]   m_addr,
  output logic [WORD_W-1:0]   m_wdata,
  input  logic                m_gnt,
  input  logic                m_retry,
  input  logic [WORD_W-1:0]   m_rdata,
  output logic                l_we,
  output logic [LOCAL_AW-1:0] l_addr,
  output logic [WORD_W-1:0]   l_wdata,
  input  logic [WORD_W-1:0]   l_rdata
);
  logic              q_empty, q_pop;
  logic [WORD_W-1:0] q_head;
  logic              desc_done, chain_end;

  dma_task_fifo #(
    .WIDTH (WORD_W),
    .DEPTH (QUEUE_DEPTH)
  ) u_queue (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_valid),
    .wr_data (push_addr),
    .rd_en   (q_pop),
    .rd_data (q_head),
    .empty   (q_empty),
    .full    (q_full)
  );

  dma_chain_seq #(
    .WORD_W   (WORD_W),
    .LOCAL_AW (LOCAL_AW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .q_empty   (q_empty),
    .q_pop     (q_pop),
    .q_head    (q_head),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_gnt     (m_gnt),
    .m_retry   (m_retry),
    .m_rdata   (m_rdata),
    .l_we      (l_we),
    .l_addr    (l_addr),
    .l_wdata   (l_wdata),
    .l_rdata   (l_rdata),
    .desc_done (desc_done),
    .chain_end (chain_end),
    .busy      (busy)
  );

  // host-visible flags; a set event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      q_overflow <= 1'b0;
      done_count <= '0;
    end else begin
      if (desc_done) done_count <= done_count + 1'b1;
      if (chain_end)                     irq <= 1'b1;
      else if (clr_wr && clr_mask[0])    irq <= 1'b0;
      if (push_valid && q_full)          q_overflow <= 1'b1;
      else if (clr_wr && clr_mask[1])    q_overflow <= 1'b0;
    end
  end

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    done_count != $past(done_count) |-> done_count == $past(done_count) + 1'b1);

  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(desc_done));

  a_r2_ovf_source: assert property (@(posedge clk) disable iff (rst)
    $rose(q_overflow) |-> $past(push_valid && q_full));

  a_r11_busy_on_count: assert property (@(posedge clk) disable iff (rst)
    done_count != $past(done_count) |-> $past(busy));

endmodule

// File: tb/dma_chain_engine_test.sv
`timescale 1ns/1ps
module dma_chain_engine_test;
  localparam int W   = 32;
  localparam int QD  = 128;
  localparam int LAW = 14;
  localparam int CNW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [W-1:0] push_addr = '0;
  logic man_clr = 1'b0;
  logic [1:0] man_mask = 2'b00;
  logic auto_clr = 1'b0;
  logic clr_wr;
  logic [1:0] clr_mask;
  logic q_full, q_overflow, irq, busy;
  logic [CNW-1:0] done_count;
  logic m_req, m_we, m_gnt = 1'b0, m_retry = 1'b0;
  logic [W-1:0] m_addr, m_wdata, m_rdata = '0;
  logic l_we;
  logic [LAW-1:0] l_addr;
  logic [W-1:0] l_wdata, l_rdata = '0;

  assign clr_wr   = man_clr | auto_clr;
  assign clr_mask = man_clr ? man_mask : 2'b01;

  always #4 clk = ~clk;

  dma_chain_engine #(.WORD_W(W), .QUEUE_DEPTH(QD), .LOCAL_AW(LAW), .COUNT_W(CNW)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_addr(push_addr),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .q_full(q_full), .q_overflow(q_overflow),
    .irq(irq), .busy(busy), .done_count(done_count), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_gnt(m_gnt), .m_retry(m_retry),
    .m_rdata(m_rdata), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata));

  int total = 0;
  int fails = 0;
  int unsigned hmem [int unsigned];
  bit exp_last [int unsigned];
  logic [W-1:0] lmem [1 << LAW];
  int unsigned stat_log [$];
  int unsigned stat_exp [$];
  bit stall = 1'b0;
  bit retry_en = 1'b1;
  bit auto_clr_en = 1'b1;
  int wait_cnt = 0;
  int retry_cnt = 0;
  int err_acc = 0;
  bit pend_stat = 1'b0;
  bit pend_last = 1'b0;
  bit pend_retry = 1'b0;
  logic [CNW-1:0] exp_done = '0;
  int unsigned fbase = 0;
  int unsigned fnext = 0;
  int cycles = 0;

  int unsigned pg_ba [16];
  int pg_words [16];
  bit pg_dir [16];
  int unsigned pg_exp [16][16];
  int unsigned pg_desc [16];
  int npages = 0;
  int unsigned big [1024];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int unsigned hrd(input int unsigned a);
    return hmem.exists(a) ? hmem[a] : 0;
  endfunction

  function automatic int unsigned lw_of(input int unsigned a);
    return (a >> 2) & ((1 << LAW) - 1);
  endfunction

  function automatic bit last_of(input int unsigned a);
    return exp_last.exists(a) ? exp_last[a] : 1'b1;
  endfunction

  // local memory model: registered read
  always @(posedge clk) begin
    if (l_we) lmem[l_addr] <= l_wdata;
    l_rdata <= lmem[l_addr];
  end

  // host slave model, driven at the falling edge
  always @(negedge clk) begin
    auto_clr = 1'b0;
    if (rst) begin
      m_gnt = 1'b0;
      m_retry = 1'b0;
    end else if (m_gnt || m_retry) begin
      if (m_retry) chk(!m_req, "R10 backoff", {31'd0, m_req}, 32'd0);
      if (pend_stat) begin
        chk(done_count == exp_done, "R9 count step", done_count, exp_done);
        chk(irq == pend_last, "R8 irq on chain end", {31'd0, irq}, {31'd0, pend_last});
        if (pend_last && auto_clr_en) auto_clr = 1'b1;
        pend_stat = 1'b0;
      end
      pend_retry = m_retry;
      m_gnt = 1'b0;
      m_retry = 1'b0;
    end else if (m_req && !stall) begin
      if (pend_retry) begin
        pend_retry = 1'b0;
      end
      if (wait_cnt != 0) wait_cnt--;
      else begin
        wait_cnt = $urandom_range(0, 2);
        if (retry_en && $urandom_range(0, 3) == 0) begin
          m_retry = 1'b1;
          retry_cnt++;
        end else begin
          m_gnt = 1'b1;
          if (m_addr >= 32'h0030_0000 && m_addr < 32'h0030_2000) err_acc++;
          if (m_we) begin
            hmem[m_addr] = m_wdata;
            if (m_addr < 32'h0010_0000 && (m_addr & 63) == 16) begin
              stat_log.push_back(m_addr - 16);
              exp_done = exp_done + 1'b1;
              pend_stat = 1'b1;
              pend_last = last_of(m_addr - 16);
            end
          end else begin
            m_rdata = hrd(m_addr);
            if (m_addr < 32'h0010_0000) begin
              if ((m_addr & 63) == 0) begin
                fbase = m_addr;
                fnext = 4;
              end else begin
                chk((m_addr & 63) == fnext && (m_addr - (m_addr & 63)) == fbase,
                    "R3 fetch order", m_addr, fbase + fnext);
                fnext = fnext + 4;
              end
            end
          end
        end
      end
    end
  end

  task automatic push(input int unsigned a);
    @(negedge clk);
    push_valid = 1'b1;
    push_addr = a;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic clear(input logic [1:0] mask);
    @(negedge clk);
    man_clr = 1'b1;
    man_mask = mask;
    @(negedge clk);
    man_clr = 1'b0;
    man_mask = 2'b00;
  endtask

  task automatic wait_done(input logic [CNW-1:0] target);
    while (!(done_count == target && !busy)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put_desc(input int unsigned da, input int unsigned ba,
                          input int unsigned len, input int unsigned ctrl,
                          input int unsigned nx);
    hmem[da]      = ba;
    hmem[da + 4]  = len;
    hmem[da + 8]  = ctrl;
    hmem[da + 12] = nx;
    hmem[da + 16] = 0;
  endtask

  task automatic run_batch(input int b);
    int nch;
    int unsigned heads [$];
    logic [CNW-1:0] base;
    npages = 0;
    stat_exp.delete();
    stat_log.delete();
    nch = $urandom_range(2, 4);
    for (int c = 0; c < nch; c++) begin
      int n;
      n = $urandom_range(1, 3);
      for (int d = 0; d < n; d++) begin
        int unsigned da, ba;
        int p;
        p = npages;
        da = 32'h1000 + b * 32'h1000 + p * 64;
        ba = 32'h0010_0000 + b * 32'h1_0000 + p * 32'h1000;
        pg_desc[p] = da;
        pg_ba[p] = ba;
        pg_words[p] = $urandom_range(1, 16);
        pg_dir[p] = 1'($urandom_range(0, 1));
        put_desc(da, ba, pg_words[p] * 4,
                 {30'd0, pg_dir[p], (d < n - 1) ? 1'b1 : 1'b0}, da + 64);
        exp_last[da] = (d == n - 1);
        if (d == 0) heads.push_back(da);
        stat_exp.push_back(da);
        for (int w = 0; w < pg_words[p]; w++) begin
          if (!pg_dir[p]) begin
            hmem[ba + 4 * w] = $urandom;
            pg_exp[p][w] = hmem[ba + 4 * w];
          end else begin
            pg_exp[p][w] = lmem[lw_of(ba + 4 * w)];
          end
        end
        npages++;
      end
    end
    base = done_count;
    foreach (heads[i]) push(heads[i]);
    wait_done(base + CNW'(npages));
    chk(done_count == base + CNW'(npages), "R9 batch count", done_count, base + CNW'(npages));
    chk(stat_log.size() == stat_exp.size(), "R7 status write count",
        stat_log.size(), stat_exp.size());
    foreach (stat_exp[i])
      if (i < stat_log.size())
        chk(stat_log[i] == stat_exp[i], "R7 chain order", stat_log[i], stat_exp[i]);
    for (int p = 0; p < npages; p++) begin
      chk(hrd(pg_desc[p] + 16) == 1, "R6 status ok", hrd(pg_desc[p] + 16), 1);
      for (int w = 0; w < pg_words[p]; w++) begin
        int unsigned act;
        act = pg_dir[p] ? hrd(pg_ba[p] + 4 * w) : lmem[lw_of(pg_ba[p] + 4 * w)];
        chk(act == pg_exp[p][w], pg_dir[p] ? "R5 local to host" : "R4 host to local",
            act, pg_exp[p][w]);
      end
    end
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    logic [CNW-1:0] base;
    int bad;
    void'($urandom(32'd7321));
    for (int i = 0; i < (1 << LAW); i++) lmem[i] = $urandom;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!irq && !q_overflow, "R8 R2 reset flags", {30'd0, irq, q_overflow}, 0);
    chk(!q_full && !busy, "R1 R11 reset idle", {30'd0, q_full, busy}, 0);
    chk(done_count == 0, "R9 reset count", done_count, 0);
    chk(!m_req && !l_we, "R10 reset quiet", {30'd0, m_req, l_we}, 0);

    // R12: one 4 KB host-to-local descriptor, level irq held
    auto_clr_en = 1'b0;
    put_desc(32'h0800, 32'h0020_0000, 4096, 0, 0);
    exp_last[32'h0800] = 1'b1;
    for (int w = 0; w < 1024; w++) begin
      big[w] = $urandom;
      hmem[32'h0020_0000 + 4 * w] = big[w];
    end
    push(32'h0800);
    wait_done(1);
    bad = 0;
    for (int w = 0; w < 1024; w++)
      if (lmem[lw_of(32'h0020_0000 + 4 * w)] != big[w]) bad++;
    chk(bad == 0, "R12 4KB words", bad, 0);
    chk(hrd(32'h0810) == 1, "R6 status after 4KB", hrd(32'h0810), 1);
    repeat (5) @(negedge clk);
    chk(irq, "R8 irq level held", {31'd0, irq}, 1);
    clear(2'b01);
    chk(!irq, "R8 irq cleared", {31'd0, irq}, 0);
    auto_clr_en = 1'b1;

    // R6 R7: bad length ends a chain that has its link bit set
    put_desc(32'h6000, 32'h0030_0000, 6, 1, 32'h6040);
    put_desc(32'h6040, 32'h0030_1000, 8, 0, 0);
    exp_last[32'h6000] = 1'b1;
    base = done_count;
    err_acc = 0;
    push(32'h6000);
    wait_done(base + 1);
    repeat (20) @(negedge clk);
    chk(hrd(32'h6010) == 3, "R6 error status", hrd(32'h6010), 3);
    chk(hrd(32'h6050) == 0, "R6 chain stops on error", hrd(32'h6050), 0);
    chk(err_acc == 0, "R6 no data access on error", err_acc, 0);
    chk(done_count == base + 1, "R9 error counted", done_count, base + 1);

    // random chains with retries
    for (int b = 0; b < 3; b++) run_batch(b);
    chk(retry_cnt > 0, "R10 retries exercised", retry_cnt, 1);
    chk(!busy, "R11 idle after batches", {31'd0, busy}, 0);

    // R1 R2: fill the queue while the bus is stalled
    stall = 1'b1;
    base = done_count;
    @(negedge clk);
    for (int i = 0; i < QD + 1; i++) begin
      push_valid = 1'b1;
      push_addr = 32'h8000 + i * 64;
      @(negedge clk);
    end
    push_valid = 1'b0;
    chk(q_full, "R1 full at depth", {31'd0, q_full}, 1);
    chk(!q_overflow, "R2 no overflow yet", {31'd0, q_overflow}, 0);
    chk(busy, "R11 busy while stalled", {31'd0, busy}, 1);
    push_valid = 1'b1;
    push_addr = 32'h8000 + (QD + 1) * 64;
    @(negedge clk);
    push_valid = 1'b0;
    chk(q_overflow, "R2 overflow set", {31'd0, q_overflow}, 1);
    repeat (3) @(negedge clk);
    chk(q_overflow, "R2 overflow sticky", {31'd0, q_overflow}, 1);
    clear(2'b10);
    chk(!q_overflow, "R2 overflow cleared", {31'd0, q_overflow}, 0);
    chk(q_full, "R1 still full", {31'd0, q_full}, 1);
    stall = 1'b0;
    wait_done(base + CNW'(QD + 1));
    chk(done_count == base + CNW'(QD + 1), "R1 accepted heads served",
        done_count, base + CNW'(QD + 1));
    chk(hrd(32'h8000 + QD * 64 + 16) == 3, "R1 last accepted head",
        hrd(32'h8000 + QD * 64 + 16), 3);
    chk(hrd(32'h8000 + (QD + 1) * 64 + 16) == 0, "R2 dropped head unserved",
        hrd(32'h8000 + (QD + 1) * 64 + 16), 0);
    chk(!q_full && !busy, "R11 idle at end", {30'd0, q_full, busy}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule